// File: doc/BRIEF.md
# JTAG Test Access Port with Initialization Instructions

This block is a JTAG test access port with the usual sixteen-state TAP controller, a 4-bit instruction register and data-register selection. It also has two instructions that prepare a chip for board-level interconnect test. The setup instruction places a parameter register between TDI and TDO. That register has a shift stage and a parallel update stage. The update stage drives the I/O and safe-mode configuration of the chip.

The run instruction places a status register in the scan path. It also fires a one-cycle start pulse toward an on-chip initialization sequencer. The pulse fires at Update-IR and does not wait for Run-Test/Idle.

The boundary scan chain is reduced to a short stub register so that the preload and external-test instructions can be used in their normal order around initialization. The parameter register is cleared only by a separate power-on reset. Test-Logic-Reset, whether reached through TMS or through `trst_n`, leaves the parameter values in place, so a later test can rerun initialization without loading them again.

Top module: `jtag_init_tap`

## Requirements
- R1: Holding TMS high for five TCK rising edges, or driving `trst_n` or `por_n` low, brings the controller to Test-Logic-Reset. Test-Logic-Reset loads the BYPASS opcode 1111, so `extest_en` is low and a data scan shows the 1-bit bypass register.
- R2: In Capture-IR the instruction shift stage loads the value 0001. Its low two bits are 01, and bit 0 is shifted out first.
- R3: The opcodes are EXTEST 0000, PRELOAD 0010, INIT_SETUP 1000, INIT_RUN 1001 and BYPASS 1111, with bit 0 shifted in first. Any other opcode selects the bypass register. The bypass register captures 0 and delays TDI by one shift.
- R4: INIT_SETUP selects the 16-bit parameter register, shifted LSB first. Capture-DR loads the current value of `init_param`. `init_param` changes only at the rising edge that leaves Update-DR.
- R5: While INIT_SETUP is the current instruction, data scans leave `bsr_out` and `extest_en` unchanged and raise no `init_start`.
- R6: When Update-IR loads INIT_RUN, `init_start` is high for exactly the one TCK cycle after the Update-IR state. This holds whether the next state is Run-Test/Idle or Select-DR-Scan.
- R7: INIT_RUN selects the 4-bit status register. Capture-DR loads `init_status`, and the register is shifted LSB first.
- R8: `init_param` keeps its value through Test-Logic-Reset reached by TMS or by `trst_n`. Only `por_n` low clears it to 0.
- R9: PRELOAD and EXTEST both select the 8-bit boundary stub. Capture-DR loads `bsr_in`, and Update-DR loads `bsr_out`. `extest_en` is high only while EXTEST is the current instruction.
- R10: TDO and `tdo_en` change only on falling TCK edges. `tdo_en` is high only during Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| por_n | input | 1 | Power-on reset, active low; also clears the parameter and boundary update stages |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| init_param | output | 16 | Parameter register update stage |
| init_start | output | 1 | One-cycle start pulse to the initialization sequencer |
| init_status | input | 4 | Sequencer status, captured under INIT_RUN |
| bsr_in | input | 8 | Parallel values captured into the boundary stub |
| bsr_out | output | 8 | Boundary stub update stage |
| extest_en | output | 1 | High while EXTEST is the current instruction |

## Verification
The hardest case to reach from the ports is an INIT_RUN start pulse taken with the TAP going directly from Update-IR to Select-DR-Scan, without ever entering Run-Test/Idle. The stimulus reaches it with a TMS sequence that ends the instruction scan with TMS held high through Update-IR.

A second hard case is parameter persistence. The parameter register is loaded, and then the TAP is reset twice, once through TMS and once through `trst_n`. The parameter register is then captured back out under INIT_SETUP and compared with the loaded value. A behavioural queue-based model of the TAP runs alongside the design and is compared with every output on every clock.

// File: rtl/jit_pkg.sv
package jit_pkg;

   typedef enum logic [3:0] {
      S_RESET   = 4'd0,
      S_IDLE    = 4'd1,
      S_SEL_DR  = 4'd2,
      S_CAP_DR  = 4'd3,
      S_SH_DR   = 4'd4,
      S_EX1_DR  = 4'd5,
      S_PAU_DR  = 4'd6,
      S_EX2_DR  = 4'd7,
      S_UPD_DR  = 4'd8,
      S_SEL_IR  = 4'd9,
      S_CAP_IR  = 4'd10,
      S_SH_IR   = 4'd11,
      S_EX1_IR  = 4'd12,
      S_PAU_IR  = 4'd13,
      S_EX2_IR  = 4'd14,
      S_UPD_IR  = 4'd15
   } tap_state_e;

   typedef enum logic [1:0] {
      SEL_BYP  = 2'd0,
      SEL_BSR  = 2'd1,
      SEL_PAR  = 2'd2,
      SEL_STAT = 2'd3
   } dr_sel_e;

endpackage

// File: rtl/jit_tap_fsm.sv
module jit_tap_fsm
   import jit_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
         S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
         S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
         S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
         S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
         S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
         S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
         S_UPD_DR: nxt = tms ? S_SEL_DR : S_IDLE;
         S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
         S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
         S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
         S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
         S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
         S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
         S_UPD_IR: nxt = tms ? S_SEL_DR : S_IDLE;
         default:  nxt = S_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= S_RESET;
      else        state <= nxt;
   end

   // R1: once in Test-Logic-Reset, TMS high keeps it there
   a_r1_reset_sticky: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_RESET && tms) |=> (state == S_RESET));

   // R1: from any state, five TMS-high edges end in Test-Logic-Reset (checked as last step)
   a_r1_sel_ir_exit: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_SEL_IR && tms) |=> (state == S_RESET));

endmodule

// File: rtl/jit_ireg.sv
module jit_ireg
   import jit_pkg::*;
#(
   parameter int               IR_W      = 4,
   parameter logic [IR_W-1:0]  OP_BYPASS = '1
)(
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic [IR_W-1:0] ir_sh
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= '0;
      end else if (state == S_CAP_IR) begin
         ir_sh <= CAP_PAT;
      end else if (state == S_SH_IR) begin
         ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                  ir_q <= OP_BYPASS;
      else if (state == S_RESET)   ir_q <= OP_BYPASS;
      else if (state == S_UPD_IR)  ir_q <= ir_sh;
   end

   a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

   a_r1_reset_bypass: assert property (@(posedge tck) disable iff (!rst_n)
      (state == S_RESET) |=> (ir_q == OP_BYPASS));

   a_r3_ir_hold: assert property (@(posedge tck) disable iff (!rst_n)
      (state != S_UPD_IR && state != S_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/jit_dreg.sv
module jit_dreg
   import jit_pkg::*;
#(
   parameter int W = 8
)(
   input  logic         tck,
   input  logic         rst_n,
   input  logic         sel,
   input  tap_state_e   state,
   input  logic         tdi,
   input  logic [W-1:0] cap_val,
   output logic         so,
   output logic [W-1:0] par_q
);

   logic [W-1:0] sh_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (sel) begin
         if (state == S_CAP_DR)      sh_q <= cap_val;
         else if (state == S_SH_DR)  sh_q <= {tdi, sh_q[W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                          par_q <= '0;
      else if (sel && state == S_UPD_DR)   par_q <= sh_q;
   end

   assign so = sh_q[0];

endmodule

// File: rtl/jtag_init_tap.sv
module jtag_init_tap
   import jit_pkg::*;
#(
   parameter int               IR_W          = 4,
   parameter int               PARAM_W       = 16,
   parameter int               STAT_W        = 4,
   parameter bit               HAS_STAT      = 1'b1,
   parameter int               BSR_W         = 8,
   parameter logic [IR_W-1:0]  OP_BYPASS     = 4'b1111,
   parameter logic [IR_W-1:0]  OP_EXTEST     = 4'b0000,
   parameter logic [IR_W-1:0]  OP_PRELOAD    = 4'b0010,
   parameter logic [IR_W-1:0]  OP_INIT_SETUP = 4'b1000,
   parameter logic [IR_W-1:0]  OP_INIT_RUN   = 4'b1001
)(
   input  logic               tck,
   input  logic               trst_n,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_en,
   output logic [PARAM_W-1:0] init_param,
   output logic               init_start,
   input  logic [STAT_W-1:0]  init_status,
   input  logic [BSR_W-1:0]   bsr_in,
   output logic [BSR_W-1:0]   bsr_out,
   output logic               extest_en
);

   if (IR_W < 2) begin : g_bad_ir
      $error("jtag_init_tap: IR_W must be at least 2");
   end
   if (PARAM_W < 2 || BSR_W < 2 || STAT_W < 2) begin : g_bad_dr
      $error("jtag_init_tap: data register widths must be at least 2");
   end
   if (OP_INIT_SETUP == OP_INIT_RUN || OP_EXTEST == OP_PRELOAD) begin : g_bad_op
      $error("jtag_init_tap: opcodes must be distinct");
   end

   logic            tap_rst_n;
   tap_state_e      state;
   logic [IR_W-1:0] ir_q;
   logic [IR_W-1:0] ir_sh;
   dr_sel_e         dr_sel;
   logic            byp_q;
   logic            bsr_so;
   logic            par_so;
   logic            stat_so;
   logic            dr_so;
   logic            shifting;

   assign tap_rst_n = trst_n & por_n;

   jit_tap_fsm u_fsm (
      .tck   (tck),
      .rst_n (tap_rst_n),
      .tms   (tms),
      .state (state)
   );

   jit_ireg #(.IR_W(IR_W), .OP_BYPASS(OP_BYPASS)) u_ir (
      .tck   (tck),
      .rst_n (tap_rst_n),
      .state (state),
      .tdi   (tdi),
      .ir_q  (ir_q),
      .ir_sh (ir_sh)
   );

   always_comb begin
      case (ir_q)
         OP_EXTEST, OP_PRELOAD: dr_sel = SEL_BSR;
         OP_INIT_SETUP:         dr_sel = SEL_PAR;
         OP_INIT_RUN:           dr_sel = HAS_STAT ? SEL_STAT : SEL_BYP;
         default:               dr_sel = SEL_BYP;
      endcase
   end

   // bypass: captures 0, one-stage delay
   always_ff @(posedge tck or negedge tap_rst_n) begin
      if (!tap_rst_n) begin
         byp_q <= 1'b0;
      end else if (dr_sel == SEL_BYP) begin
         if (state == S_CAP_DR)     byp_q <= 1'b0;
         else if (state == S_SH_DR) byp_q <= tdi;
      end
   end

   // parameter register: power-on reset only, survives Test-Logic-Reset
   jit_dreg #(.W(PARAM_W)) u_param (
      .tck     (tck),
      .rst_n   (por_n),
      .sel     (dr_sel == SEL_PAR),
      .state   (state),
      .tdi     (tdi),
      .cap_val (init_param),
      .so      (par_so),
      .par_q   (init_param)
   );

   jit_dreg #(.W(BSR_W)) u_bsr (
      .tck     (tck),
      .rst_n   (por_n),
      .sel     (dr_sel == SEL_BSR),
      .state   (state),
      .tdi     (tdi),
      .cap_val (bsr_in),
      .so      (bsr_so),
      .par_q   (bsr_out)
   );

   if (HAS_STAT) begin : g_stat
      logic [STAT_W-1:0] stat_sh;
      always_ff @(posedge tck or negedge tap_rst_n) begin
         if (!tap_rst_n) begin
            stat_sh <= '0;
         end else if (dr_sel == SEL_STAT) begin
            if (state == S_CAP_DR)     stat_sh <= init_status;
            else if (state == S_SH_DR) stat_sh <= {tdi, stat_sh[STAT_W-1:1]};
         end
      end
      assign stat_so = stat_sh[0];
   end else begin : g_no_stat
      assign stat_so = 1'b0;
   end

   always_comb begin
      unique case (dr_sel)
         SEL_BSR:  dr_so = bsr_so;
         SEL_PAR:  dr_so = par_so;
         SEL_STAT: dr_so = stat_so;
         default:  dr_so = byp_q;
      endcase
   end

   // start pulse fires at Update-IR, independent of Run-Test/Idle
   always_ff @(posedge tck or negedge tap_rst_n) begin
      if (!tap_rst_n) init_start <= 1'b0;
      else            init_start <= (state == S_UPD_IR) && (ir_sh == OP_INIT_RUN);
   end

   assign shifting = (state == S_SH_IR) || (state == S_SH_DR);

   always_ff @(negedge tck or negedge tap_rst_n) begin
      if (!tap_rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= shifting;
         tdo    <= !shifting ? 1'b0 : (state == S_SH_IR) ? ir_sh[0] : dr_so;
      end
   end

   assign extest_en = (ir_q == OP_EXTEST);

   a_r6_start_single: assert property (@(posedge tck) disable iff (!tap_rst_n)
      init_start |=> !init_start);

   a_r6_start_with_run: assert property (@(posedge tck) disable iff (!tap_rst_n)
      init_start |-> (ir_q == OP_INIT_RUN));

   a_r4_param_hold: assert property (@(posedge tck) disable iff (!por_n)
      !(state == S_UPD_DR && dr_sel == SEL_PAR) |=> $stable(init_param));

   a_r9_bsr_hold: assert property (@(posedge tck) disable iff (!por_n)
      !(state == S_UPD_DR && dr_sel == SEL_BSR) |=> $stable(bsr_out));

   a_r5_setup_keeps_bsr: assert property (@(posedge tck) disable iff (!tap_rst_n)
      (ir_q == OP_INIT_SETUP && state != S_UPD_IR) |=> ($stable(bsr_out) && !extest_en));

endmodule

// File: tb/jtag_init_tap_tb_top.sv
`timescale 1ns/1ps
module jtag_init_tap_tb_top;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        por_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo, tdo_en, init_start, extest_en;
   logic [15:0] init_param;
   logic [3:0]  init_status = 4'h0;
   logic [7:0]  bsr_in = 8'h00;
   logic [7:0]  bsr_out;

   int checks = 0;
   int errs   = 0;
   bit s_tdo;

   always #4 tck = ~tck;

   jtag_init_tap dut_i (
      .tck(tck), .trst_n(trst_n), .por_n(por_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_en(tdo_en), .init_param(init_param),
      .init_start(init_start), .init_status(init_status),
      .bsr_in(bsr_in), .bsr_out(bsr_out), .extest_en(extest_en)
   );

   // ---------------- behavioural reference model ----------------
   int        st = 0;
   bit [3:0]  irq = 4'hF;
   bit [15:0] m_par = '0;
   bit [7:0]  m_bout = '0;
   bit        m_start = 0;
   bit        m_tdo = 0, m_en = 0;
   bit        dq[$];
   bit        iq[$];

   function automatic int nxt(int s, bit m);
      case (s)
         0: return m ? 0 : 1;    1: return m ? 2 : 1;
         2: return m ? 9 : 3;    3: return m ? 5 : 4;
         4: return m ? 5 : 4;    5: return m ? 8 : 6;
         6: return m ? 7 : 6;    7: return m ? 8 : 4;
         8: return m ? 2 : 1;    9: return m ? 0 : 10;
         10: return m ? 12 : 11; 11: return m ? 12 : 11;
         12: return m ? 15 : 13; 13: return m ? 14 : 13;
         14: return m ? 15 : 11; 15: return m ? 2 : 1;
         default: return 0;
      endcase
   endfunction

   function automatic int dsel(bit [3:0] op);
      if (op == 4'b0000 || op == 4'b0010) return 1;
      if (op == 4'b1000) return 2;
      if (op == 4'b1001) return 3;
      return 0;
   endfunction

   function automatic bit [31:0] qval(bit q[$]);
      bit [31:0] v = '0;
      for (int i = 0; i < q.size(); i++) v[i] = q[i];
      return v;
   endfunction

   task automatic fillq(input bit [31:0] v, input int n);
      dq.delete();
      for (int i = 0; i < n; i++) dq.push_back(v[i]);
   endtask

   always @(posedge tck or negedge trst_n or negedge por_n) begin
      if (!por_n) begin m_par = '0; m_bout = '0; end
      if (!trst_n || !por_n) begin
         st = 0; irq = 4'hF; m_start = 0;
      end else begin
         m_start = (st == 15) && (qval(iq) == 32'h9);
         case (st)
            0:  irq = 4'hF;
            10: begin iq.delete(); iq.push_back(1); iq.push_back(0); iq.push_back(0); iq.push_back(0); end
            11: begin void'(iq.pop_front()); iq.push_back(tdi); end
            15: irq = qval(iq);
            3: begin
               case (dsel(irq))
                  1: fillq(bsr_in, 8);
                  2: fillq(m_par, 16);
                  3: fillq(init_status, 4);
                  default: fillq(0, 1);
               endcase
            end
            4: begin void'(dq.pop_front()); dq.push_back(tdi); end
            8: begin
               if (dsel(irq) == 2) m_par  = qval(dq);
               if (dsel(irq) == 1) m_bout = qval(dq);
            end
            default: ;
         endcase
         st = nxt(st, tms);
      end
   end

   always @(negedge tck or negedge trst_n or negedge por_n) begin
      if (!trst_n || !por_n) begin m_tdo = 0; m_en = 0; end
      else if (st == 11) begin m_en = 1; m_tdo = iq[0]; end
      else if (st == 4)  begin m_en = 1; m_tdo = dq[0]; end
      else begin m_en = 0; m_tdo = 0; end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp_model();
      chk(tdo_en === m_en, "R10 tdo_en vs model", tdo_en, m_en);
      if (m_en) chk(tdo === m_tdo, "R10 tdo vs model", tdo, m_tdo);
      else      chk(tdo === 1'b0, "R10 tdo idle low", tdo, 0);
      chk(init_param === m_par, "R4 init_param vs model", init_param, m_par);
      chk(init_start === m_start, "R6 init_start vs model", init_start, m_start);
      chk(bsr_out === m_bout, "R9 bsr_out vs model", bsr_out, m_bout);
      chk(extest_en === (irq == 4'h0), "R9 extest_en vs model", extest_en, irq == 4'h0);
   endtask

   task automatic tick(input bit m, input bit d);
      @(negedge tck); #1;
      tms = m; tdi = d;
      #2;
      cmp_model();
      s_tdo = tdo;
      if (tdo_en) begin
         @(posedge tck); #1;
         chk(tdo === s_tdo, "R10 tdo held over rising edge", tdo, s_tdo);
      end
   endtask

   task automatic ir(input bit [3:0] op, input bit via_idle, output bit [3:0] cap);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 4; i++) begin tick(i == 3, op[i]); cap[i] = s_tdo; end
      tick(1, 0);
      tick(via_idle ? 1'b0 : 1'b1, 0);
   endtask

   task automatic dr(input int n, input bit [31:0] din, output bit [31:0] cap);
      cap = '0;
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin tick(i == n - 1, din[i]); cap[i] = s_tdo; end
      tick(1, 0); tick(0, 0);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      bit [3:0]  c4;
      bit [31:0] c;
      repeat (3) @(posedge tck);
      @(negedge tck); trst_n = 1; por_n = 1;
      #3;
      chk(tdo_en === 0 && tdo === 0, "R1 reset tdo", {tdo_en, tdo}, 0);
      chk(init_param === 16'h0, "R8 reset init_param", init_param, 0);
      chk(extest_en === 0 && init_start === 0, "R1 reset outputs", {extest_en, init_start}, 0);

      tick(0, 0);
      dr(4, 32'b1101, c);
      chk(c[3:0] == 4'b1010, "R1 bypass after reset", c[3:0], 4'b1010);

      ir(4'b1111, 1, c4);
      chk(c4 == 4'b0001, "R2 capture-IR pattern", c4, 4'b0001);

      bsr_in = 8'h96;
      ir(4'b1000, 1, c4);
      dr(16, 32'hA5C3, c);
      chk(c[15:0] == 16'h0000, "R4 first capture", c[15:0], 0);
      tick(0, 0);
      chk(init_param === 16'hA5C3, "R4 update value", init_param, 16'hA5C3);
      chk(bsr_out === 8'h00 && extest_en === 0, "R5 setup leaves chip", {extest_en, bsr_out}, 0);
      dr(16, 32'h1234, c);
      chk(c[15:0] == 16'hA5C3, "R4 capture of update stage", c[15:0], 16'hA5C3);
      tick(0, 0);
      chk(init_start === 0, "R5 no start under setup", init_start, 0);

      repeat (5) tick(1, 0);
      tick(0, 0);
      chk(init_param === 16'h1234, "R8 kept over TMS reset", init_param, 16'h1234);

      ir(4'b0010, 1, c4);
      dr(8, 32'h3C, c);
      chk(c[7:0] == 8'h96, "R9 preload capture", c[7:0], 8'h96);
      tick(0, 0);
      chk(bsr_out === 8'h3C && extest_en === 0, "R9 preload update", {extest_en, bsr_out}, 9'h03C);

      init_status = 4'hA;
      ir(4'b1001, 1, c4);
      tick(0, 0);
      chk(init_start === 1, "R6 start after Update-IR", init_start, 1);
      tick(0, 0);
      chk(init_start === 0, "R6 start single cycle", init_start, 0);
      dr(4, 32'h0, c);
      chk(c[3:0] == 4'hA, "R7 status capture", c[3:0], 4'hA);

      ir(4'b1001, 0, c4);
      tick(1, 0);
      chk(init_start === 1, "R6 start without idle", init_start, 1);
      tick(1, 0);
      chk(init_start === 0, "R6 pulse ended", init_start, 0);
      tick(0, 0);

      ir(4'b0101, 1, c4);
      dr(3, 32'b011, c);
      chk(c[2:0] == 3'b110, "R3 unknown opcode is bypass", c[2:0], 3'b110);

      ir(4'b0000, 1, c4);
      tick(0, 0);
      chk(extest_en === 1 && bsr_out === 8'h3C, "R9 extest select", {extest_en, bsr_out}, 9'h13C);
      chk(tdo_en === 0 && tdo === 0, "R10 idle tdo", {tdo_en, tdo}, 0);

      @(negedge tck); #1; trst_n = 0; #6; trst_n = 1;
      tick(0, 0);
      chk(extest_en === 0, "R1 trst loads bypass", extest_en, 0);
      chk(init_param === 16'h1234, "R8 kept over trst", init_param, 16'h1234);

      ir(4'b1000, 1, c4);
      dr(16, 32'h1234, c);
      chk(c[15:0] == 16'h1234, "R8 reuse after resets", c[15:0], 16'h1234);

      @(negedge tck); #1; por_n = 0; #6; por_n = 1;
      tick(0, 0);
      chk(init_param === 16'h0, "R8 por clears", init_param, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++; errs++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule